// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block generates two independent pulse-width modulated outputs from one system clock. Software programs it through a small word-addressed register bus with a write strobe and combinational read data. The two channels share a single control word, and each channel has its own timing word holding a period count and an active count. Each channel divides the system clock by a selectable ratio, or uses it undivided. It advances a 16-bit counter on every divided tick and drives its output to the active level while the counter is below the active count.

The output polarity can be set per channel. A channel only produces its waveform while both its clock-gate bit and its run bit are set; otherwise it rests at its inactive level. A new timing word is held in a shadow copy and flagged as pending. A stopped channel takes it on the next cycle. A running channel takes it only at the end of the period in progress, so no period is ever cut short or stretched.

Top module: `twin_pwm`

## Requirements
- R1: After reset every register reads 0, the pending flags read 0, and because the polarity bit resets to 0 both outputs rest at their inactive level, which is high.
- R2: The control word is at byte address 0x0 and channel n's timing word is at 0x4+4n. Channel n's field group starts at control bit 15n and holds the divider code in bits [3:0], the run bit at 4, polarity at 5, clock gate at 6, and two stored-only bits at 7 and 8. All nine bits read back as written. Bits outside the groups read 0, except the pending flags. The timing word holds period-1 in bits [31:16] and the active count in bits [15:0], and it reads back as written.
- R3: A running channel's counter counts 0 up to the period field and then returns to 0, so one period lasts field+1 ticks. The output is at the active level while the counter is below the active count.
- R4: With polarity bit 1 the active level is high. With polarity bit 0 the active level is low and the inactive level is high.
- R5: An active count of 0 holds the output at the inactive level. An active count above the period field holds it at the active level.
- R6: Unless both the clock-gate bit and the run bit of a channel are 1, its counter is held at 0 and its output sits at the inactive level.
- R7: Divider code 15 advances the counter on every clock.
- R8: Divider codes 0 to 4 divide by 120, 180, 240, 360 and 480, and codes 8 to 12 divide by 12000, 24000, 36000, 48000 and 72000. Codes 5, 6, 7, 13 and 14 freeze the counter.
- R9: A write to a timing word sets control bit 28+n the next cycle. On a stopped channel the new values take effect, and the flag clears, one cycle later.
- R10: On a running channel a new timing word takes effect only at the tick that ends the current period. Until then the old period and active count stay in use.
- R11: A control write that changes a channel's divider code while writing its clock-gate bit as 0 resets that channel's divider. The first tick after restart therefore comes a full ratio of clocks after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | NUM_CH | Modulated outputs, one bit per channel |

## Verification
A register write takes effect at the edge that samples it. A channel enabled at edge E shows counter value 0 in the cycle right after E, and its output is combinational from registers, so a waveform is due from that cycle. The driver queues one expected output bit per cycle at edge E, and the monitor compares one bit each cycle, 2 ns after the rising edge. A deferred update written at edge E+7 on a five-tick period is expected to show up from cycle 11 after E. Pending flags are read in the cycle right after the write edge and again one cycle later, when a stopped channel has already taken the new values.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;

  localparam int GROUP_STRIDE = 15;
  localparam int READY_BASE   = 28;
  localparam int PRD_LSB      = 16;
  localparam int CFG_W        = 9;
  localparam int DIV_W        = 17;
  localparam logic [3:0] CODE_BYPASS = 4'hF;

  // One channel's field group; packing order mirrors bits [8:0] of its group.
  typedef struct packed {
    logic       pulse;
    logic       mode;
    logic       gate;
    logic       act;
    logic       run;
    logic [3:0] code;
  } chanCfg_t;

  // Strobes from register control to the datapath of one channel.
  typedef struct packed {
    logic divClear;
    logic updPending;
  } chanStrobe_t;

  // Division ratio per divider code; 0 means the code freezes the counter.
  function automatic logic [DIV_W-1:0] divRatio(input logic [3:0] code);
    logic [DIV_W-1:0] r;
    case (code)
      4'd0:    r = DIV_W'(120);
      4'd1:    r = DIV_W'(180);
      4'd2:    r = DIV_W'(240);
      4'd3:    r = DIV_W'(360);
      4'd4:    r = DIV_W'(480);
      4'd8:    r = DIV_W'(12000);
      4'd9:    r = DIV_W'(24000);
      4'd10:   r = DIV_W'(36000);
      4'd11:   r = DIV_W'(48000);
      4'd12:   r = DIV_W'(72000);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/twin_pwm_ctrl.sv
module twin_pwm_ctrl
  import twin_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWrEn,
  input  logic [31:0]                    busWrData,
  output logic [31:0]                    busRdData,
  input  logic [NUM_CH-1:0]              loadAck,
  output chanCfg_t [NUM_CH-1:0]          chanCfg,
  output logic [NUM_CH-1:0][CNT_W-1:0]   shadowPrd,
  output logic [NUM_CH-1:0][CNT_W-1:0]   shadowDuty,
  output logic [NUM_CH-1:0]              pending,
  output chanStrobe_t [NUM_CH-1:0]       strobes
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              ctrlSel;
  logic [NUM_CH-1:0] chanSel;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign ctrlSel = (wordIdx == '0);

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_sel
      assign chanSel[n] = (wordIdx == WORD_W'(n + 1));
    end
  endgenerate

  // Per-channel register state and strobes
  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_reg
      chanCfg_t newCfg;
      logic     ctrlWrite;
      logic     timingWrite;

      assign newCfg      = chanCfg_t'(busWrData[n*GROUP_STRIDE +: CFG_W]);
      assign ctrlWrite   = busWrEn && ctrlSel;
      assign timingWrite = busWrEn && chanSel[n];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          chanCfg[n] <= '0;
        end else if (ctrlWrite) begin
          chanCfg[n] <= newCfg;
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          shadowPrd[n]  <= '0;
          shadowDuty[n] <= '0;
          pending[n]    <= 1'b0;
        end else if (timingWrite) begin
          shadowPrd[n]  <= busWrData[PRD_LSB +: CNT_W];
          shadowDuty[n] <= busWrData[0 +: CNT_W];
          pending[n]    <= 1'b1;
        end else if (loadAck[n]) begin
          pending[n]    <= 1'b0;
        end
      end

      // Divider restart: code changes while the gate is written as clear
      assign strobes[n].divClear   = ctrlWrite && !newCfg.gate &&
                                     (newCfg.code != chanCfg[n].code);
      assign strobes[n].updPending = pending[n];
    end
  endgenerate

  // Read mux
  always_comb begin
    busRdData = '0;
    if (ctrlSel) begin
      for (int n = 0; n < NUM_CH; n++) begin
        busRdData[n*GROUP_STRIDE +: CFG_W] = chanCfg[n];
        busRdData[READY_BASE + n]          = pending[n];
      end
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (chanSel[n]) begin
          busRdData[PRD_LSB +: CNT_W] = shadowPrd[n];
          busRdData[0 +: CNT_W]       = shadowDuty[n];
        end
      end
    end
  end

endmodule

// File: rtl/twin_pwm_datapath.sv
module twin_pwm_datapath
  import twin_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  chanCfg_t [NUM_CH-1:0]         chanCfg,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  shadowPrd,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  shadowDuty,
  input  chanStrobe_t [NUM_CH-1:0]      strobes,
  output logic [NUM_CH-1:0]             loadAck,
  output logic [NUM_CH-1:0][CNT_W-1:0]  chanCnt,
  output logic [NUM_CH-1:0][CNT_W-1:0]  chanPrd,
  output logic [NUM_CH-1:0][CNT_W-1:0]  chanDuty,
  output logic [NUM_CH-1:0]             pwmOut
);

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      logic [DIV_W-1:0] ratio;
      logic [DIV_W-1:0] preDiv;
      logic             bypass;
      logic             divOk;
      logic             divEnd;
      logic             running;
      logic             tick;
      logic             wrap;
      logic             loadNow;
      logic             inActive;

      assign ratio   = divRatio(chanCfg[n].code);
      assign bypass  = (chanCfg[n].code == CODE_BYPASS);
      assign divOk   = (ratio != '0);
      assign divEnd  = divOk && (preDiv == ratio - DIV_W'(1));
      assign running = chanCfg[n].gate && chanCfg[n].run;

      // Clock divider runs whenever the clock gate is open
      always_ff @(posedge clk) begin
        if (!rstN) begin
          preDiv <= '0;
        end else if (strobes[n].divClear) begin
          preDiv <= '0;
        end else if (chanCfg[n].gate && divOk && !bypass) begin
          preDiv <= divEnd ? '0 : preDiv + DIV_W'(1);
        end
      end

      assign tick    = running && (bypass || divEnd);
      assign wrap    = tick && (chanCnt[n] == chanPrd[n]);
      assign loadNow = strobes[n].updPending && (!running || wrap);

      // Period counter
      always_ff @(posedge clk) begin
        if (!rstN) begin
          chanCnt[n] <= '0;
        end else if (!running) begin
          chanCnt[n] <= '0;
        end else if (tick) begin
          chanCnt[n] <= wrap ? '0 : chanCnt[n] + CNT_W'(1);
        end
      end

      // Working copy of period and active count
      always_ff @(posedge clk) begin
        if (!rstN) begin
          chanPrd[n]  <= '0;
          chanDuty[n] <= '0;
        end else if (loadNow) begin
          chanPrd[n]  <= shadowPrd[n];
          chanDuty[n] <= shadowDuty[n];
        end
      end

      assign loadAck[n] = loadNow;
      assign inActive   = running && (chanCnt[n] < chanDuty[n]);
      assign pwmOut[n]  = inActive ? chanCfg[n].act : !chanCfg[n].act;
    end
  endgenerate

endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
  import twin_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [NUM_CH-1:0] pwmOut
);

  chanCfg_t    [NUM_CH-1:0]            chanCfg;
  chanStrobe_t [NUM_CH-1:0]            strobes;
  logic        [NUM_CH-1:0][CNT_W-1:0] shadowPrd;
  logic        [NUM_CH-1:0][CNT_W-1:0] shadowDuty;
  logic        [NUM_CH-1:0][CNT_W-1:0] chanCnt;
  logic        [NUM_CH-1:0][CNT_W-1:0] chanPrd;
  logic        [NUM_CH-1:0][CNT_W-1:0] chanDuty;
  logic        [NUM_CH-1:0]            pending;
  logic        [NUM_CH-1:0]            loadAck;

  twin_pwm_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .loadAck    (loadAck),
    .chanCfg    (chanCfg),
    .shadowPrd  (shadowPrd),
    .shadowDuty (shadowDuty),
    .pending    (pending),
    .strobes    (strobes)
  );

  twin_pwm_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .chanCfg    (chanCfg),
    .shadowPrd  (shadowPrd),
    .shadowDuty (shadowDuty),
    .strobes    (strobes),
    .loadAck    (loadAck),
    .chanCnt    (chanCnt),
    .chanPrd    (chanPrd),
    .chanDuty   (chanDuty),
    .pwmOut     (pwmOut)
  );

endmodule

// File: rtl/twin_pwm_checker.sv
module twin_pwm_checker
  import twin_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             busAddr,
  input logic                          busWrEn,
  input chanCfg_t [NUM_CH-1:0]         chanCfg,
  input logic [NUM_CH-1:0]             pending,
  input logic [NUM_CH-1:0][CNT_W-1:0]  chanCnt,
  input logic [NUM_CH-1:0][CNT_W-1:0]  chanPrd,
  input logic [NUM_CH-1:0][CNT_W-1:0]  chanDuty,
  input logic [NUM_CH-1:0]             pwmOut
);

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      logic isRunning;
      assign isRunning = chanCfg[n].gate && chanCfg[n].run;

      AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
        chanCnt[n] <= chanPrd[n]); // R3

      AST_ZERO_DUTY_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
        (isRunning && chanDuty[n] == '0) |-> (pwmOut[n] == !chanCfg[n].act)); // R5

      AST_STOPPED_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
        !isRunning |-> (pwmOut[n] == !chanCfg[n].act)); // R6

      AST_PENDING_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
        (busWrEn && busAddr[ADDR_W-1:2] == (ADDR_W-2)'(n + 1)) |=> pending[n]); // R9

      AST_NO_MIDPERIOD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        (chanCnt[n] != '0) |-> ($stable(chanPrd[n]) && $stable(chanDuty[n]))); // R10
    end
  endgenerate

endmodule

bind twin_pwm twin_pwm_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .chanCfg  (chanCfg),
  .pending  (pending),
  .chanCnt  (chanCnt),
  .chanPrd  (chanPrd),
  .chanDuty (chanDuty),
  .pwmOut   (pwmOut)
);

// File: tb/sim_twin_pwm.sv
`timescale 1ns/1ps
module sim_twin_pwm;

  localparam int NUM_CH = 2;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NUM_CH-1:0] pwmOut;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  finished = 1'b0;

  int    qCh[$];
  bit    qVal[$];
  string qTag[$];

  always #4 clk = ~clk;   // 125 MHz

  twin_pwm #(.NUM_CH(NUM_CH), .CNT_W(16), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  function automatic logic [31:0] cfgWord(int ch, int code, bit run, bit act, bit gate);
    logic [8:0] g;
    g = {2'b00, gate, act, run, 4'(code)};
    return 32'(g) << (15 * ch);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected output bit per cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (qCh.size() > 0) begin
        int    ch;
        bit    v;
        string t;
        ch = qCh.pop_front();
        v  = qVal.pop_front();
        t  = qTag.pop_front();
        check(t, 32'(pwmOut[ch]), 32'(v));
      end
    end
  end

  task automatic pushConst(int ch, bit v, int n, string tag);
    for (int k = 0; k < n; k++) begin
      qCh.push_back(ch); qVal.push_back(v); qTag.push_back(tag);
    end
  endtask

  // Expected waveform from the requirement: count = (k / clocksPerTick) mod (P+1)
  task automatic pushWave(int ch, int prdField, int duty, bit act, int n, int perTick, string tag);
    for (int k = 0; k < n; k++) begin
      int c;
      c = (k / perTick) % (prdField + 1);
      qCh.push_back(ch); qVal.push_back((c < duty) ? act : !act); qTag.push_back(tag);
    end
  endtask

  task automatic busIssue(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
  endtask

  task automatic busRelease();
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    busIssue(a, d);
    busRelease();
  endtask

  task automatic readCheck(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  task automatic waitDrain();
    while (qCh.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    readCheck(4'h0, 32'h0, "R1 ctrl");
    readCheck(4'h4, 32'h0, "R1 timing0");
    readCheck(4'h8, 32'h0, "R1 timing1");
    check("R1 outputs", 32'(pwmOut), 32'h3);

    // R2: readback of fields; stray and read-only bits ignored
    busWrite(4'h0, (32'h0A3 << 15) | 32'h18C | 32'h9000_0C00);
    readCheck(4'h0, (32'h0A3 << 15) | 32'h18C, "R2 ctrl readback");
    busWrite(4'h4, 32'h1234_5678);
    readCheck(4'h4, 32'h1234_5678, "R2 timing readback");
    busWrite(4'h0, 32'h0);

    // R9: stopped channel takes timing word one cycle after the flag rises
    busWrite(4'h4, {16'd4, 16'd2});
    busAddr = 4'h0; #1;
    check("R9 pending set ch0", 32'(busRdData[28]), 32'h1);
    @(negedge clk); #1;
    check("R9 pending cleared ch0", 32'(busRdData[28]), 32'h0);

    // R3/R7 bypass waveform, then R10 deferred update
    busIssue(4'h0, cfgWord(0, 15, 1, 1, 1));
    pushWave(0, 4, 2, 1'b1, 10, 1, "R3 bypass period 5 duty 2");
    pushConst(0, 1'b1, 6, "R10 update at period end");
    busRelease();
    repeat (6) @(posedge clk);
    busIssue(4'h4, {16'd2, 16'd3});
    busRelease();
    waitDrain();

    // R6: gate without run, run without gate
    busIssue(4'h0, cfgWord(0, 15, 0, 1, 1));
    pushConst(0, 1'b0, 4, "R6 gate only");
    busRelease(); waitDrain();
    busIssue(4'h0, cfgWord(0, 15, 1, 1, 0));
    pushConst(0, 1'b0, 4, "R6 run only");
    busRelease(); waitDrain();
    busIssue(4'h0, cfgWord(0, 15, 0, 0, 1));
    pushConst(0, 1'b1, 4, "R4 R6 inverted idle level");
    busRelease(); waitDrain();

    // R5: zero active count
    busWrite(4'h4, {16'd3, 16'd0});
    busIssue(4'h0, cfgWord(0, 15, 1, 1, 1));
    pushConst(0, 1'b0, 8, "R5 zero duty");
    busRelease(); waitDrain();

    // R4: inverted channel 1, ch0 stopped
    busWrite(4'h0, 32'h0);
    busWrite(4'h8, {16'd3, 16'd1});
    busAddr = 4'h0; #1;
    check("R9 pending set ch1", 32'(busRdData[29]), 32'h1);
    @(negedge clk); #1;
    check("R9 pending cleared ch1", 32'(busRdData[29]), 32'h0);
    busIssue(4'h0, cfgWord(1, 15, 1, 0, 1));
    pushWave(1, 3, 1, 1'b0, 12, 1, "R4 inverted polarity");
    busRelease(); waitDrain();
    check("R6 ch0 idle while ch1 runs", 32'(pwmOut[0]), 32'h1);

    // R8: divide by 120
    busWrite(4'h0, 32'h0);
    busWrite(4'h4, {16'd1, 16'd1});
    busWrite(4'h0, cfgWord(0, 0, 0, 1, 0));
    busIssue(4'h0, cfgWord(0, 0, 1, 1, 1));
    pushWave(0, 1, 1, 1'b1, 360, 120, "R8 divide 120");
    busRelease(); waitDrain();
    repeat (37) @(posedge clk);

    // R11: code change with gate clear restarts divider; R8 divide 180
    busWrite(4'h0, cfgWord(0, 1, 0, 1, 0));
    busIssue(4'h0, cfgWord(0, 1, 1, 1, 1));
    pushWave(0, 1, 1, 1'b1, 360, 180, "R11 clean restart divide 180");
    busRelease(); waitDrain();

    // R8: unused code freezes counter at 0
    busWrite(4'h0, cfgWord(0, 5, 0, 1, 1));
    busIssue(4'h0, cfgWord(0, 5, 1, 1, 1));
    pushConst(0, 1'b1, 200, "R8 frozen code");
    busRelease(); waitDrain();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule